// File: doc/BRIEF.md
# Coalesced Memory Request Shrinker

This block takes one coalesced memory transaction and issues the smallest aligned request that still covers every 32-byte chunk the transaction uses. A transaction arrives as a base address, a nominal segment size (32, 64 or 128 bytes) and a 4-bit mask. The mask marks which 32-byte chunks are in use inside the 128-byte region that contains the base address. The lane mask and the byte mask ride along untouched.

The reduction has two steps. A 128-byte segment whose chunks all sit in one half is first cut to 64 bytes at that half's address. Any 64-byte result is then cut to 32 bytes if only one chunk of its pair is in use. When the nominal segment is 64 bytes, bit 6 of the address picks which chunk pair belongs to it. An error flag marks a base address that is misaligned for its segment, a reserved size code and an empty chunk mask.

The result is held in a one-entry registered stage with a valid/ready handshake on both sides. This stage can accept a new transaction in the same cycle that it hands over the previous one.

Top module: `txn_shrink`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: Size codes are 0 = 32 bytes, 1 = 64 bytes, 2 = 128 bytes and 3 = reserved. For a nominal 128-byte segment whose chunk mask has bits only in [1:0], the first step gives 64 bytes at the unchanged address, and R5 is then applied.
- R3: For a nominal 128-byte segment whose chunk mask has bits only in [3:2], the first step gives 64 bytes at the address plus 64, and R5 is then applied.
- R4: A nominal 128-byte segment with chunks used in both halves leaves as 128 bytes at the unchanged address.
- R5: A 64-byte intermediate with only the lower chunk of its pair used becomes 32 bytes at the same address. With only the upper chunk used, it becomes 32 bytes at the address plus 32. With both chunks used, or with neither, it stays 64 bytes.
- R6: For a nominal 64-byte segment, the pair is chunks {1,0} when address bit 6 is 0 and chunks {3,2} when it is 1.
- R7: A nominal 32-byte segment, or the reserved code 3, leaves with its size code and address unchanged.
- R8: out_err is 1 when the size code is 3, or when the address is not a multiple of the nominal segment size.
- R9: out_err is 1 when the chunk mask is 0000.
- R10: out_lanes and out_bytes equal the lane mask and byte mask of the same transaction.
- R11: While out_valid is 1 and out_ready is 0, every output stays unchanged in the next cycle.
- R12: in_ready equals (not out_valid) or out_ready. A transaction accepted at a clock edge appears on the outputs with out_valid 1 right after that edge, so the stage sustains one transaction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transaction present |
| in_ready | output | 1 | Stage can take a transaction |
| in_addr | input | ADDR_W | Base address |
| in_seg | input | 2 | Nominal segment size code |
| in_chunks | input | 4 | 32-byte chunks used in the 128-byte region |
| in_lanes | input | LANES | Lane mask |
| in_bytes | input | BYTES | Byte mask |
| out_valid | output | 1 | Output request present |
| out_ready | input | 1 | Consumer takes the request |
| out_addr | output | ADDR_W | Reduced request address |
| out_size | output | 2 | Reduced size code |
| out_lanes | output | LANES | Lane mask passed through |
| out_bytes | output | BYTES | Byte mask passed through |
| out_err | output | 1 | Alignment, size-code or empty-mask error |

## Verification
Two things can happen in the same cycle: the stage holds a stalled result, and a new input transaction arrives; or the held result is handed over while the next one is loaded. The consumer's ready is randomized independently of the producer's valid, which provokes all of these overlaps. A stalled result must stay bit-for-bit stable, and no new input may be accepted while the stage is full. Every result that is handed over is compared in order against a reference model built on a chunk-span formulation, so a lost, duplicated or overwritten entry shows up as a miscompare.

// File: rtl/txn_shrink.sv
module txn_shrink #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 32,
  parameter int BYTES  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_seg,
  input  logic [3:0]        in_chunks,
  input  logic [LANES-1:0]  in_lanes,
  input  logic [BYTES-1:0]  in_bytes,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [1:0]        out_size,
  output logic [LANES-1:0]  out_lanes,
  output logic [BYTES-1:0]  out_bytes,
  output logic              out_err
);
  localparam logic [1:0] SZ32  = 2'd0;
  localparam logic [1:0] SZ64  = 2'd1;
  localparam logic [1:0] SZ128 = 2'd2;
  localparam logic [ADDR_W-1:0] HALF_OFS  = ADDR_W'(64);
  localparam logic [ADDR_W-1:0] CHUNK_OFS = ADDR_W'(32);

  logic              lo_used, hi_used, misalign, take;
  logic [1:0]        pair, mid_size, red_size;
  logic [ADDR_W-1:0] mid_addr, red_addr;

  assign lo_used  = |in_chunks[1:0];
  assign hi_used  = |in_chunks[3:2];
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    mid_size = in_seg;
    mid_addr = in_addr;
    pair     = in_addr[6] ? in_chunks[3:2] : in_chunks[1:0];
    if (in_seg == SZ128) begin
      if (lo_used && !hi_used) begin
        mid_size = SZ64;
        pair     = in_chunks[1:0];
      end else if (hi_used && !lo_used) begin
        mid_size = SZ64;
        mid_addr = in_addr + HALF_OFS;
        pair     = in_chunks[3:2];
      end
    end
  end

  always_comb begin
    red_size = mid_size;
    red_addr = mid_addr;
    if (mid_size == SZ64) begin
      if (pair == 2'b01) begin
        red_size = SZ32;
      end else if (pair == 2'b10) begin
        red_size = SZ32;
        red_addr = mid_addr + CHUNK_OFS;
      end
    end
  end

  always_comb begin
    case (in_seg)
      SZ32:    misalign = |in_addr[4:0];
      SZ64:    misalign = |in_addr[5:0];
      SZ128:   misalign = |in_addr[6:0];
      default: misalign = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_size  <= SZ32;
      out_lanes <= '0;
      out_bytes <= '0;
      out_err   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (take) begin
        out_addr  <= red_addr;
        out_size  <= red_size;
        out_lanes <= in_lanes;
        out_bytes <= in_bytes;
        out_err   <= misalign || (in_chunks == 4'b0000);
      end
    end
  end
endmodule

// File: rtl/txn_shrink_chk.sv
module txn_shrink_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 32,
  parameter int BYTES  = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic [1:0]        in_seg,
  input logic [3:0]        in_chunks,
  input logic [LANES-1:0]  in_lanes,
  input logic [BYTES-1:0]  in_bytes,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_size,
  input logic [LANES-1:0]  out_lanes,
  input logic [BYTES-1:0]  out_bytes,
  input logic              out_err
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_size)
      && $stable(out_err) && $stable(out_lanes) && $stable(out_bytes));

  assert_full_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_empty_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_chunks == 4'b0000 |=> out_err);

  assert_pass_small_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_seg == 2'd0 |=> out_size == 2'd0 && out_addr == $past(in_addr));

  assert_no_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_seg != 2'd3 |=> out_size <= $past(in_seg));

  assert_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_lanes == $past(in_lanes) && out_bytes == $past(in_bytes));
endmodule

bind txn_shrink txn_shrink_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTES(BYTES)) u_chk (.*);

// File: tb/txn_shrink_test.sv
`timescale 1ns/1ps
module txn_shrink_test;
  localparam int ADDR_W = 32;
  localparam int LANES  = 32;
  localparam int BYTES  = 128;
  localparam int EXP_W  = 1 + 2 + ADDR_W + LANES + BYTES;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [1:0]        in_seg = '0;
  logic [3:0]        in_chunks = '0;
  logic [LANES-1:0]  in_lanes = '0;
  logic [BYTES-1:0]  in_bytes = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [ADDR_W-1:0] out_addr;
  logic [1:0]        out_size;
  logic [LANES-1:0]  out_lanes;
  logic [BYTES-1:0]  out_bytes;
  logic              out_err;

  int checks = 0;
  int fails = 0;
  logic [EXP_W-1:0] expq[$];

  always #2.5 clk = ~clk;

  txn_shrink #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTES(BYTES)) uut (.*);

  function automatic logic [ADDR_W+2:0] model(input logic [ADDR_W-1:0] a,
                                               input logic [1:0] s, input logic [3:0] c);
    logic bad;
    logic [1:0] sz;
    logic [ADDR_W-1:0] ad;
    logic [1:0] p;
    sz = s;
    ad = a;
    case (s)
      2'd0: bad = (a % 32) != 0;
      2'd1: bad = (a % 64) != 0;
      2'd2: bad = (a % 128) != 0;
      default: bad = 1'b1;
    endcase
    bad = bad || (c == 0);
    if (s == 2'd2 && c != 0) begin
      if ($countones(c) == 1) begin
        sz = 2'd0;
        for (int k = 0; k < 4; k++) if (c[k]) ad = a + 32 * k;
      end else if (c[3:2] == 0) sz = 2'd1;
      else if (c[1:0] == 0) begin sz = 2'd1; ad = a + 64; end
    end else if (s == 2'd1) begin
      p = a[6] ? c[3:2] : c[1:0];
      if (p == 2'b01) sz = 2'd0;
      else if (p == 2'b10) begin sz = 2'd0; ad = a + 32; end
    end
    return {bad, sz, ad};
  endfunction

  function automatic string tag_of(input logic [ADDR_W-1:0] a, input logic [1:0] s,
                                   input logic [3:0] c);
    if (s == 2'd3) return "R8";
    if (c == 0) return "R9";
    if (s == 2'd0) return "R7";
    if (s == 2'd1) return "R6/R5";
    if ((a % 128) != 0) return "R8";
    if ($countones(c) == 1) return "R5";
    if (c[3:2] == 0) return "R2";
    if (c[1:0] == 0) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input logic [EXP_W-1:0] got, input logic [EXP_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pick(input int i);
    in_lanes = $urandom;
    in_bytes = {$urandom, $urandom, $urandom, $urandom};
    case (i)
      0:  begin in_addr = 32'h1000; in_seg = 2; in_chunks = 4'b0011; end // R2
      1:  begin in_addr = 32'h1080; in_seg = 2; in_chunks = 4'b1100; end // R3
      2:  begin in_addr = 32'h1000; in_seg = 2; in_chunks = 4'b1001; end // R4
      3:  begin in_addr = 32'h2000; in_seg = 2; in_chunks = 4'b0100; end // R5
      4:  begin in_addr = 32'h2040; in_seg = 1; in_chunks = 4'b1100; end // R6
      5:  begin in_addr = 32'h2040; in_seg = 1; in_chunks = 4'b0011; end // R6
      6:  begin in_addr = 32'h2000; in_seg = 1; in_chunks = 4'b0010; end // R5
      7:  begin in_addr = 32'h2040; in_seg = 1; in_chunks = 4'b0100; end // R6
      8:  begin in_addr = 32'h3020; in_seg = 0; in_chunks = 4'b1111; end // R7
      9:  begin in_addr = 32'h3010; in_seg = 2; in_chunks = 4'b1111; end // R8
      10: begin in_addr = 32'h4000; in_seg = 2; in_chunks = 4'b0000; end // R9
      11: begin in_addr = 32'h4000; in_seg = 3; in_chunks = 4'b0001; end // R8
      default: begin
        in_seg = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
        in_addr = $urandom;
        if ($urandom % 8 != 0)
          in_addr = in_addr & ~((32'd32 << in_seg) - 1);
        in_chunks = ($urandom % 10 == 0) ? 4'b0000 : 4'($urandom);
      end
    endcase
  endtask

  initial begin
    int n;
    logic pending, held, prev_acc;
    logic [EXP_W-1:0] snap, exp;
    string tq[$];
    void'($urandom(32'h0000_5eed));
    pending = 0; held = 0; prev_acc = 0; n = 0;
    repeat (3) @(negedge clk);
    check("R1", {in_ready, out_valid}, {1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {in_ready, out_valid}, {1'b1, 1'b0});
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (prev_acc) check("R12", {EXP_W'(out_valid)}, {EXP_W'(1)});
      if (held && out_valid)
        check("R11", {out_err, out_size, out_addr, out_lanes, out_bytes}, snap);
      else if (held) check("R11", {EXP_W'(out_valid)}, {EXP_W'(1)});
      out_ready = (cyc < 30) ? 1'b1 : (cyc > 3900) ? 1'b1 : ($urandom % 3 != 0);
      if (!pending) begin
        if (cyc > 3900) in_valid = 1'b0;
        else begin
          in_valid = (cyc < 30) ? 1'b1 : ($urandom % 4 != 0);
          if (in_valid) begin pick(n); n++; end
        end
      end
      #0.2;
      if (in_ready !== (!out_valid || out_ready)) check("R12", {EXP_W'(in_ready)}, {EXP_W'(!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check("R12", {EXP_W'(1)}, {EXP_W'(0)});
        else begin
          exp = expq.pop_front();
          check(tq.pop_front(), {out_err, out_size, out_addr}, exp[EXP_W-1:LANES+BYTES]);
          check("R10", {out_lanes, out_bytes}, exp[LANES+BYTES-1:0]);
        end
      end
      prev_acc = in_valid && in_ready;
      if (prev_acc) begin
        expq.push_back({model(in_addr, in_seg, in_chunks), in_lanes, in_bytes});
        tq.push_back(tag_of(in_addr, in_seg, in_chunks));
      end
      held = out_valid && !out_ready;
      snap = {out_err, out_size, out_addr, out_lanes, out_bytes};
      pending = in_valid && !in_ready;
    end
    check("R12", {EXP_W'(expq.size())}, {EXP_W'(0)});
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule